// File: doc/BRIEF.md
# Translation Buffer with Use and Modify Tracking

This block is a small, fully associative address translation cache. Each of its entries maps a virtual page number to a physical frame number. Each entry also carries three status bits: a valid bit, a use (reference) bit and a modify (dirty) bit. A lookup compares the page number of the incoming virtual address against every valid entry in the same cycle. On a hit it returns the physical address and the index of the matching entry.

As a side effect of a successful lookup, the hardware marks the matching entry as used. When the lookup is for a store, it also marks the entry as modified. Page-replacement software works through a management port. That port can sample one entry's use and modify bits, clear one entry's use bit, clear the use bits of all entries at once, and refill an entry with a new mapping. Page-table walking and victim selection are left to software.

Top module: `tlb_refdirty`

## Requirements
- R1: After reset every entry is invalid and every use and modify bit is 0. No lookup hits, and every sample returns 0 for both bits.
- R2: When `lk_valid` is high and the address's page number matches a valid entry, `lk_hit` is 1 in the same cycle. `lk_index` is then the entry number, and `lk_paddr` is that entry's frame number concatenated with the untouched low 12 offset bits of the address.
- R3: A lookup that matches no valid entry gives `lk_hit`=0, `lk_index`=0 and `lk_paddr`=0, and it changes no status bit. This includes an address whose page number equals that of an invalid entry.
- R4: A hitting lookup sets the use bit of the matched entry at the next clock edge.
- R5: A hitting lookup with `lk_store`=1 also sets the matched entry's modify bit. A hitting lookup with `lk_store`=0 leaves the modify bit unchanged.
- R6: When `mg_cmd`=1 (sample), `mg_ref` and `mg_dirty` show the use and modify bits of entry `mg_idx` as they stood before that cycle's edge. With any other command both outputs are 0.
- R7: When `mg_cmd`=2 (clear one), the use bit of entry `mg_idx` is reset. Other entries' use bits and all modify bits are unaffected.
- R8: When `mg_cmd`=3 (clear all), every use bit is reset at a single clock edge, and all modify bits are kept.
- R9: If a hitting lookup and a clear-one or clear-all on the same entry fall in the same cycle, the use bit of that entry ends up set.
- R10: When `mg_cmd`=4 (refill), entry `mg_idx` takes `mg_vpn` and `mg_pfn`, becomes valid, and has its use and modify bits cleared. This holds even if a lookup hits that entry in the same cycle. Command codes 0 and 5 to 7 do nothing.
- R11: If several valid entries hold the same page number, the lowest-numbered one is reported, and only it has its status bits updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address: page number in bits 31:12, offset in bits 11:0 |
| lk_store | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_index | output | 4 | Matching entry number |
| lk_paddr | output | 32 | Translated physical address |
| mg_cmd | input | 3 | Management command: 0 idle, 1 sample, 2 clear one, 3 clear all, 4 refill |
| mg_idx | input | 4 | Entry selected by sample, clear one or refill |
| mg_vpn | input | 20 | Page number for refill |
| mg_pfn | input | 20 | Frame number for refill |
| mg_ref | output | 1 | Sampled use bit |
| mg_dirty | output | 1 | Sampled modify bit |

## Verification
The hardest situations to reach are collisions within one cycle: a hitting lookup that meets a clear-one, a clear-all, a sample or a refill aimed at the same entry, and two valid entries sharing one page number. The bench drives the lookup and the management command on the same clock edge to produce each collision. To create duplicate page numbers, it refills one entry with a page number already held by another entry. The result is then read back through a later sample or lookup.

// File: rtl/tlb_refdirty.sv
module tlb_refdirty #(
  parameter int ENTRIES = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int VA_W = VPN_W + OFF_W,
  localparam int PA_W = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_index,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic [2:0]       mg_cmd,
  input  logic [IDX_W-1:0] mg_idx,
  input  logic [VPN_W-1:0] mg_vpn,
  input  logic [PFN_W-1:0] mg_pfn,
  output logic             mg_ref,
  output logic             mg_dirty
);
  localparam logic [2:0] CMD_SAMPLE = 3'd1;
  localparam logic [2:0] CMD_CLR1   = 3'd2;
  localparam logic [2:0] CMD_CLRALL = 3'd3;
  localparam logic [2:0] CMD_WRITE  = 3'd4;

  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, ref_q, dirty_q;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign lk_hit   = lk_valid && (|match);
  assign lk_index = lk_hit ? hit_idx : '0;
  assign lk_paddr = lk_hit ? {pfn_q[hit_idx], lk_vaddr[OFF_W-1:0]} : '0;

  wire sampling = (mg_cmd == CMD_SAMPLE);
  assign mg_ref   = sampling && ref_q[mg_idx];
  assign mg_dirty = sampling && dirty_q[mg_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        pfn_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (mg_cmd == CMD_WRITE && mg_idx == IDX_W'(i)) begin
          vpn_q[i]   <= mg_vpn;
          pfn_q[i]   <= mg_pfn;
          valid_q[i] <= 1'b1;
          ref_q[i]   <= 1'b0;
          dirty_q[i] <= 1'b0;
        end else begin
          if (lk_hit && hit_idx == IDX_W'(i))
            ref_q[i] <= 1'b1;
          else if (mg_cmd == CMD_CLRALL || (mg_cmd == CMD_CLR1 && mg_idx == IDX_W'(i)))
            ref_q[i] <= 1'b0;
          if (lk_hit && lk_store && hit_idx == IDX_W'(i))
            dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  always_comb
    if (rst_n && lk_hit)
      assert_hit_entry_R2: assert (valid_q[lk_index] && vpn_q[lk_index] == lk_vpn);

  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_hit && (mg_cmd == 3'd0 || mg_cmd == CMD_SAMPLE)
    |=> $stable(ref_q) && $stable(dirty_q) && $stable(valid_q));

  assert_use_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && !(mg_cmd == CMD_WRITE && mg_idx == lk_index) |=> ref_q[$past(lk_index)]);

  assert_store_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && lk_store && !(mg_cmd == CMD_WRITE && mg_idx == lk_index)
    |=> dirty_q[$past(lk_index)]);

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mg_cmd == CMD_CLRALL && !lk_hit |=> ref_q == '0 && $stable(dirty_q));

  assert_hit_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && (mg_cmd == CMD_CLRALL || (mg_cmd == CMD_CLR1 && mg_idx == lk_index))
    |=> ref_q[$past(lk_index)]);

  assert_refill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mg_cmd == CMD_WRITE && int'(mg_idx) < ENTRIES
    |=> valid_q[$past(mg_idx)] && !ref_q[$past(mg_idx)] && !dirty_q[$past(mg_idx)]
        && pfn_q[$past(mg_idx)] == $past(mg_pfn));
endmodule

// File: tb/tb_tlb_refdirty.sv
module tb_tlb_refdirty;
  localparam int PERIOD = 10;
  localparam int N = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_store = 0;
  logic        lk_hit;
  logic [3:0]  lk_index;
  logic [31:0] lk_paddr;
  logic [2:0]  mg_cmd = '0;
  logic [3:0]  mg_idx = '0;
  logic [19:0] mg_vpn = '0;
  logic [19:0] mg_pfn = '0;
  logic        mg_ref, mg_dirty;

  int checks = 0;
  int errors = 0;

  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  logic [N-1:0] m_v, m_r, m_d;

  tlb_refdirty dut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [19:0] vpn_of(int i);
    return 20'h01000 + 20'(i * 37);
  endfunction
  function automatic logic [19:0] pfn_of(int i);
    return 20'hA0000 + 20'(i * 4113);
  endfunction

  task automatic check(logic ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(logic lv, logic [31:0] va, logic st, logic [2:0] cmd, int idx,
                       logic [19:0] vp, logic [19:0] pf, string tag);
    logic mh;
    int mi;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; lk_store = st;
    mg_cmd = cmd; mg_idx = 4'(idx); mg_vpn = vp; mg_pfn = pf;
    #1;
    mh = 0; mi = 0;
    if (lv)
      for (int i = N - 1; i >= 0; i--)
        if (m_v[i] && m_vpn[i] == va[31:12]) begin mh = 1; mi = i; end
    check(lk_hit == mh, tag, "hit", 32'(lk_hit), 32'(mh));
    check(lk_index == 4'(mi), tag, "index", 32'(lk_index), 32'(mi));
    check(lk_paddr == (mh ? {m_pfn[mi], va[11:0]} : 32'h0), tag, "paddr", lk_paddr,
          mh ? {m_pfn[mi], va[11:0]} : 32'h0);
    check(mg_ref == (cmd == 3'd1 && m_r[idx]), tag, "sample use", 32'(mg_ref),
          32'(cmd == 3'd1 && m_r[idx]));
    check(mg_dirty == (cmd == 3'd1 && m_d[idx]), tag, "sample modify", 32'(mg_dirty),
          32'(cmd == 3'd1 && m_d[idx]));
    for (int i = 0; i < N; i++) begin
      if (cmd == 3'd4 && idx == i) begin
        m_vpn[i] = vp; m_pfn[i] = pf; m_v[i] = 1; m_r[i] = 0; m_d[i] = 0;
      end else begin
        if (mh && mi == i) m_r[i] = 1;
        else if (cmd == 3'd3 || (cmd == 3'd2 && idx == i)) m_r[i] = 0;
        if (mh && st && mi == i) m_d[i] = 1;
      end
    end
    @(posedge clk);
  endtask

  task automatic sample_all(string tag);
    for (int i = 0; i < N; i++) cycle(0, 32'h0, 0, 3'd1, i, '0, '0, tag);
  endtask

  task automatic lookup(int page_src, logic [11:0] off, logic st, string tag);
    cycle(1, {vpn_of(page_src), off}, st, 3'd0, 0, '0, '0, tag);
  endtask

  initial begin
    m_v = '0; m_r = '0; m_d = '0;
    for (int i = 0; i < N; i++) begin m_vpn[i] = '0; m_pfn[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 / R3: reset state, page 0 matches only invalid entries
    cycle(1, 32'h0000_0ABC, 1, 3'd0, 0, '0, '0, "R1_R3 reset lookup");
    sample_all("R1 reset sample");

    // R10: refill every entry
    for (int i = 0; i < N; i++) cycle(0, '0, 0, 3'd4, i, vpn_of(i), pfn_of(i), "R10 refill");
    sample_all("R10 after refill");

    // R2 / R4 / R5: translate every entry, stores on odd entries
    for (int i = 0; i < N; i++) lookup(i, 12'(i * 257), i[0], "R2_R4_R5 lookup");
    sample_all("R4_R5 status");

    // R3: misses leave everything alone; unknown codes do nothing (R10)
    cycle(1, 32'hFFFF_F123, 1, 3'd0, 0, '0, '0, "R3 miss");
    cycle(1, 32'h0000_0000, 1, 3'd5, 2, 20'h1, 20'h2, "R3_R10 miss unused code");
    cycle(0, '0, 0, 3'd7, 3, 20'h1, 20'h2, "R10 unused code");
    sample_all("R3 status after miss");

    // R7: clear even entries one at a time
    for (int i = 0; i < N; i += 2) cycle(0, '0, 0, 3'd2, i, '0, '0, "R7 clear one");
    sample_all("R7 status");

    // R8: clear all
    cycle(0, '0, 0, 3'd3, 0, '0, '0, "R8 clear all");
    sample_all("R8 status");

    // R9: hit collides with clear one / clear all
    cycle(1, {vpn_of(5), 12'h055}, 0, 3'd2, 5, '0, '0, "R9 hit vs clear one");
    cycle(1, {vpn_of(8), 12'h088}, 1, 3'd3, 0, '0, '0, "R9 hit vs clear all");
    sample_all("R9 status");

    // R6: sample in the same cycle as a hit shows the old value
    cycle(1, {vpn_of(2), 12'h222}, 1, 3'd1, 2, '0, '0, "R6 sample with hit");
    cycle(0, '0, 0, 3'd1, 2, '0, '0, "R6 sample after hit");
    cycle(0, '0, 0, 3'd0, 2, '0, '0, "R6 idle sample outputs");

    // R10: refill wins over a same-cycle store hit
    cycle(1, {vpn_of(7), 12'h777}, 1, 3'd4, 7, 20'h7777F, 20'h3C3C3, "R10 refill vs hit");
    cycle(0, '0, 0, 3'd1, 7, '0, '0, "R10 status after refill");
    cycle(1, 32'h7777_F010, 0, 3'd0, 0, '0, '0, "R10 new mapping");
    lookup(7, 12'h010, 0, "R10 old mapping");

    // R11: duplicate page numbers, lowest index wins
    cycle(0, '0, 0, 3'd3, 0, '0, '0, "R11 clear all");
    cycle(0, '0, 0, 3'd4, 12, vpn_of(4), 20'h55555, "R11 duplicate refill");
    lookup(4, 12'hFED, 1, "R11 duplicate lookup");
    cycle(0, '0, 0, 3'd1, 12, '0, '0, "R11 upper untouched");
    cycle(0, '0, 0, 3'd1, 4, '0, '0, "R11 lower marked");
    cycle(0, '0, 0, 3'd4, 4, 20'h0ABCD, 20'h12345, "R11 replace lower");
    lookup(4, 12'h001, 0, "R11 upper now hits");
    sample_all("R11 final status");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule